// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block switches bytes between the channels of a set of time-division multiplexed streams. Each channel time a slot strobe presents one byte from every input stream, all for the same channel number. The block stores those bytes in a data memory that has two halves, chosen by frame parity. For every output stream it reads a 16-bit connection word for the channel being built. The word either names a source stream and source channel, whose stored byte is then sent out, or carries a constant byte supplied by the host.

Each connection word also sets a per-slot output enable, a control bit that appears one channel ahead of its slot, a loopback switch, and a choice between a fixed one-frame delay and a variable delay. The variable delay takes the byte from the current frame when that byte has already arrived. A host port writes and reads any connection word, one per cycle. A two-bit rate select sets the number of channels per frame to a quarter, half or all of the maximum.

Top module: `tsi_switch`

## Requirements
- R1: A slot strobe with `frame_sync` high is channel 0 of a new frame and flips the frame parity. Each other strobe advances the channel by one and wraps to 0 after channel N-1. `tx_ch` reports the channel of the slot on the outputs.
- R2: `rate_sel` 0 gives N = CH_MAX/4, 1 gives CH_MAX/2, and 2 or 3 gives CH_MAX. Only the low log2(N) bits of the source channel field (word bits 6:0) are used.
- R3: When word bit 13 is 0, output stream n carries the stored byte of the source stream (word bits 10:7) at the source channel.
- R4: `tx_vld` is high exactly two clock cycles after each slot strobe, for one cycle, and low otherwise.
- R5: When word bit 14 is 1 (constant delay), the source byte is always the one received in the previous frame.
- R6: When word bit 14 is 0 (variable delay), the source byte comes from the current frame if the source channel is lower than the current channel, and from the previous frame otherwise.
- R7: When word bit 13 is 1, the output byte is word bits 7:0, whatever the source fields hold.
- R8: `tx_oe[n]` equals word bit 11 of stream n's slot while `tx_vld` is high, and is 0 while `tx_vld` is low.
- R9: When word bit 15 of output stream n, channel m is 1, the byte stored for input stream n, channel m is the byte transmitted on that slot, and `rx_bytes` for it is ignored.
- R10: With the outputs of channel m, `tx_cco[n]` carries word bit 12 of stream n for the following channel ((m+1) mod N). Bit 0 belongs to stream 0, and streams rise with bit position.
- R11: `host_we` writes `host_wdata` to the word at address stream*CH_MAX+channel. `host_rdata` shows, one cycle later, the word at the address presented, as it was before any write in that same cycle. A word written before a strobe is used for that strobe's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_stb | input | 1 | One channel time; inputs sampled on this cycle |
| frame_sync | input | 1 | Marks the strobe that opens a frame |
| rate_sel | input | 2 | Channel count select |
| rx_bytes | input | NS*8 | Input bytes, stream n at bits n*8+7:n*8 |
| tx_bytes | output | NS*8 | Output bytes, stream n at bits n*8+7:n*8 |
| tx_oe | output | NS | Per-stream output enable for the slot |
| tx_cco | output | NS | Control bits for the next channel |
| tx_vld | output | 1 | Output slot valid |
| tx_ch | output | CHW | Channel of the output slot |
| host_we | input | 1 | Connection word write |
| host_addr | input | AW | Word address, stream*CH_MAX+channel |
| host_wdata | input | 16 | Word to write |
| host_rdata | output | 16 | Word read back |

## Verification
The bench builds the switch with NS=4 and CH_MAX=16, so the three rates give 4, 8 and 16 channels. At that size every output slot of every frame is checked against an arithmetic reference, under all three rates. The connection pattern mixes variable and constant delay across each frame, so sources behind and ahead of the current channel both occur. It also puts bits above the rate mask in the channel field, and ends with a frame set that uses loopback with constant bytes.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    // Connection word layout; field positions are decoded by the switch.
    typedef struct packed {
        logic       loop;      // 15
        logic       fixed_dly; // 14
        logic       const_out; // 13
        logic       ctl_bit;   // 12
        logic       drive;     // 11
        logic [3:0] src_strm;  // 10:7
        logic [6:0] src_chan;  // 6:0
    } conn_word_t;

    localparam logic [1:0] RATE_QUARTER = 2'd0;
    localparam logic [1:0] RATE_HALF    = 2'd1;

endpackage

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr #(
    parameter int CH_MAX = 128,
    localparam int CHW   = $clog2(CH_MAX)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slot_stb,
    input  logic           frame_sync,
    input  logic [1:0]     rate_sel,
    output logic [CHW-1:0] cur_ch,
    output logic           cur_par,
    output logic [CHW-1:0] nxt_ch,
    output logic [CHW-1:0] ch_mask
);
    import tsi_pkg::*;

    typedef struct packed {
        logic [CHW-1:0] ch;
        logic           par;
    } ctr_t;

    ctr_t d, q;
    logic [CHW:0] nch;
    logic [CHW:0] last;

    always_comb begin
        case (rate_sel)
            RATE_QUARTER: nch = (CHW+1)'(CH_MAX / 4);
            RATE_HALF:    nch = (CHW+1)'(CH_MAX / 2);
            default:      nch = (CHW+1)'(CH_MAX);
        endcase
        last    = nch - 1'b1;
        ch_mask = last[CHW-1:0];

        if (frame_sync) begin
            cur_ch  = '0;
            cur_par = ~q.par;
        end else begin
            cur_ch  = ({1'b0, q.ch} >= last) ? '0 : q.ch + 1'b1;
            cur_par = q.par;
        end
        nxt_ch = ({1'b0, cur_ch} == last) ? '0 : cur_ch + 1'b1;

        d = q;
        if (slot_stb) begin
            d.ch  = cur_ch;
            d.par = cur_par;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ch  <= CHW'(CH_MAX - 1);
            q.par <= 1'b0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem #(
    parameter int NS     = 16,
    parameter int CH_MAX = 128,
    localparam int CHW   = $clog2(CH_MAX),
    localparam int SW    = $clog2(NS),
    localparam int AW    = SW + CHW,
    localparam int DEPTH = NS * CH_MAX
) (
    input  logic                  clk,
    input  logic                  host_we,
    input  logic [AW-1:0]         host_addr,
    input  logic [15:0]           host_wdata,
    output logic [15:0]           host_rdata,
    input  logic [CHW-1:0]        rd_ch_cur,
    input  logic [CHW-1:0]        rd_ch_nxt,
    output logic [NS-1:0][15:0]   word_cur,
    output logic [NS-1:0][15:0]   word_nxt
);
    logic [15:0] words [DEPTH];
    logic [15:0] rdata_d, rdata_q;

    always_comb rdata_d = words[host_addr];

    always_ff @(posedge clk) begin
        if (host_we) begin
            words[host_addr] <= host_wdata;
        end
        rdata_q <= rdata_d;
    end

    assign host_rdata = rdata_q;

    for (genvar n = 0; n < NS; n++) begin : g_port
        localparam logic [SW-1:0] SID = SW'(n);
        assign word_cur[n] = words[{SID, rd_ch_cur}];
        assign word_nxt[n] = words[{SID, rd_ch_nxt}];
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem #(
    parameter int NS     = 16,
    parameter int CH_MAX = 128,
    localparam int CHW   = $clog2(CH_MAX),
    localparam int SW    = $clog2(NS),
    localparam int DAW   = 1 + SW + CHW,
    localparam int DEPTH = 2 * NS * CH_MAX
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic                  wr_par,
    input  logic [CHW-1:0]        wr_ch,
    input  logic [NS-1:0][7:0]    wr_data,
    input  logic [NS-1:0][DAW-1:0] rd_addr,
    output logic [NS-1:0][7:0]    rd_data
);
    logic [7:0] bytes_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int n = 0; n < NS; n++) begin
                bytes_q[{wr_par, SW'(n), wr_ch}] <= wr_data[n];
            end
        end
    end

    for (genvar n = 0; n < NS; n++) begin : g_rd
        assign rd_data[n] = bytes_q[rd_addr[n]];
    end

endmodule

// File: rtl/tsi_switch.sv
module tsi_switch #(
    parameter int NS     = 16,
    parameter int CH_MAX = 128,
    localparam int CHW   = $clog2(CH_MAX),
    localparam int SW    = $clog2(NS),
    localparam int AW    = SW + CHW,
    localparam int DAW   = 1 + SW + CHW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_stb,
    input  logic              frame_sync,
    input  logic [1:0]        rate_sel,
    input  logic [NS*8-1:0]   rx_bytes,
    output logic [NS*8-1:0]   tx_bytes,
    output logic [NS-1:0]     tx_oe,
    output logic [NS-1:0]     tx_cco,
    output logic              tx_vld,
    output logic [CHW-1:0]    tx_ch,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata
);
    import tsi_pkg::*;

    typedef struct packed {
        logic                       s1_vld;
        logic                       s1_par;
        logic [CHW-1:0]             s1_ch;
        logic [CHW-1:0]             s1_mask;
        logic [NS-1:0][7:0]         s1_rx;
        logic [NS-1:0][15:0]        s1_word;
        logic [NS-1:0]              s1_cco;
        logic                       tx_vld;
        logic [CHW-1:0]             tx_ch;
        logic [NS-1:0][7:0]         tx_b;
        logic [NS-1:0]              tx_oe;
        logic [NS-1:0]              tx_cco;
    } pipe_t;

    pipe_t d, q;

    logic [CHW-1:0]          cur_ch, nxt_ch, ch_mask;
    logic                    cur_par;
    logic [NS-1:0][15:0]     word_cur, word_nxt;
    logic [NS-1:0][DAW-1:0]  rd_addr;
    logic [NS-1:0][7:0]      rd_data;
    logic [NS-1:0][7:0]      out_byte;
    logic [NS-1:0][7:0]      store_byte;
    logic [NS-1:0]           drive_vec;

    tsi_slot_ctr #(.CH_MAX(CH_MAX)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_stb   (slot_stb),
        .frame_sync (frame_sync),
        .rate_sel   (rate_sel),
        .cur_ch     (cur_ch),
        .cur_par    (cur_par),
        .nxt_ch     (nxt_ch),
        .ch_mask    (ch_mask)
    );

    tsi_conn_mem #(.NS(NS), .CH_MAX(CH_MAX)) u_cmem (
        .clk        (clk),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .rd_ch_cur  (cur_ch),
        .rd_ch_nxt  (nxt_ch),
        .word_cur   (word_cur),
        .word_nxt   (word_nxt)
    );

    tsi_data_mem #(.NS(NS), .CH_MAX(CH_MAX)) u_dmem (
        .clk     (clk),
        .wr_en   (q.s1_vld),
        .wr_par  (q.s1_par),
        .wr_ch   (q.s1_ch),
        .wr_data (store_byte),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    // Stage 2: source selection per output stream.
    always_comb begin
        for (int n = 0; n < NS; n++) begin
            conn_word_t     w;
            logic [CHW-1:0] src_c;
            logic [SW-1:0]  src_s;
            logic           use_cur;
            w       = conn_word_t'(q.s1_word[n]);
            src_c   = w.src_chan[CHW-1:0] & q.s1_mask;
            src_s   = w.src_strm[SW-1:0];
            use_cur = !w.fixed_dly && (src_c < q.s1_ch);
            rd_addr[n]    = {use_cur ? q.s1_par : ~q.s1_par, src_s, src_c};
            out_byte[n]   = w.const_out ? q.s1_word[n][7:0] : rd_data[n];
            store_byte[n] = w.loop ? out_byte[n] : q.s1_rx[n];
            drive_vec[n]  = w.drive;
        end
    end

    always_comb begin
        d = q;
        d.s1_vld = slot_stb;
        if (slot_stb) begin
            d.s1_par  = cur_par;
            d.s1_ch   = cur_ch;
            d.s1_mask = ch_mask;
            for (int n = 0; n < NS; n++) begin
                d.s1_rx[n]   = rx_bytes[n*8 +: 8];
                d.s1_word[n] = word_cur[n];
                d.s1_cco[n]  = word_nxt[n][12];
            end
        end
        d.tx_vld = q.s1_vld;
        d.tx_oe  = '0;
        d.tx_cco = '0;
        if (q.s1_vld) begin
            d.tx_ch  = q.s1_ch;
            d.tx_b   = out_byte;
            d.tx_oe  = drive_vec;
            d.tx_cco = q.s1_cco;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tx_bytes = q.tx_b;
    assign tx_oe    = q.tx_oe;
    assign tx_cco   = q.tx_cco;
    assign tx_vld   = q.tx_vld;
    assign tx_ch    = q.tx_ch;

endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk #(
    parameter int NS     = 16,
    parameter int CH_MAX = 128,
    localparam int CHW   = $clog2(CH_MAX),
    localparam int AW    = $clog2(NS) + CHW
) (
    input logic           clk,
    input logic           rst_n,
    input logic           slot_stb,
    input logic           frame_sync,
    input logic           tx_vld,
    input logic [CHW-1:0] tx_ch,
    input logic           host_we,
    input logic [AW-1:0]  host_addr,
    input logic [15:0]    host_wdata,
    input logic [15:0]    host_rdata
);
    // R4
    strobe_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |=> ##1 tx_vld);

    // R4
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_stb |=> ##1 !tx_vld);

    // R1
    sync_is_chan0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb && frame_sync) |=> ##1 (tx_ch == '0));

    // R11
    host_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_we ##1 (!host_we && host_addr == $past(host_addr))
        |=> (host_rdata == $past(host_wdata, 2)));

endmodule

bind tsi_switch tsi_switch_chk #(.NS(NS), .CH_MAX(CH_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_stb   (slot_stb),
    .frame_sync (frame_sync),
    .tx_vld     (tx_vld),
    .tx_ch      (tx_ch),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata)
);

// File: tb/tsi_switch_bench.sv
module tsi_switch_bench;
    localparam int NS     = 4;
    localparam int CH_MAX = 16;
    localparam int CHW    = $clog2(CH_MAX);
    localparam int AW     = $clog2(NS) + CHW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              slot_stb = 1'b0;
    logic              frame_sync = 1'b0;
    logic [1:0]        rate_sel = 2'd2;
    logic [NS*8-1:0]   rx_bytes = '0;
    logic [NS*8-1:0]   tx_bytes;
    logic [NS-1:0]     tx_oe;
    logic [NS-1:0]     tx_cco;
    logic              tx_vld;
    logic [CHW-1:0]    tx_ch;
    logic              host_we = 1'b0;
    logic [AW-1:0]     host_addr = '0;
    logic [15:0]       host_wdata = '0;
    logic [15:0]       host_rdata;

    always #2.5 clk = ~clk;

    tsi_switch #(.NS(NS), .CH_MAX(CH_MAX)) u_tsi_switch (
        .clk(clk), .rst_n(rst_n), .slot_stb(slot_stb), .frame_sync(frame_sync),
        .rate_sel(rate_sel), .rx_bytes(rx_bytes), .tx_bytes(tx_bytes),
        .tx_oe(tx_oe), .tx_cco(tx_cco), .tx_vld(tx_vld), .tx_ch(tx_ch),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [15:0] cm    [NS][CH_MAX];
    logic [7:0]  store [2][NS][CH_MAX];
    bit          known [2][NS][CH_MAX];
    int m_ch  = CH_MAX - 1;
    int m_par = 0;
    int nch   = CH_MAX;
    int frame = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_rate(input int r);
        rate_sel = 2'(r);
        nch = (r == 0) ? CH_MAX / 4 : (r == 1) ? CH_MAX / 2 : CH_MAX;
    endtask

    task automatic host_write(input int n, input int m, input logic [15:0] w);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = AW'(n * CH_MAX + m);
        host_wdata = w;
        @(negedge clk);
        host_we = 1'b0;
        cm[n][m] = w;
    endtask

    function automatic logic [15:0] mk(input bit lp, input bit cd, input bit pc,
                                       input bit cc, input bit oe, input int s,
                                       input int c, input int k);
        logic [15:0] w;
        w = {lp, cd, pc, cc, oe, 4'(s), 7'(c)};
        if (pc) w[7:0] = 8'(k);
        return w;
    endfunction

    task automatic do_slot(input bit sync);
        logic [7:0] exp_b [NS];
        bit         exp_k [NS];
        logic [7:0] rx    [NS];
        int nxt;
        if (sync) begin
            m_ch = 0; m_par ^= 1; frame++;
        end else begin
            m_ch = (m_ch >= nch - 1) ? 0 : m_ch + 1;
        end
        nxt = (m_ch == nch - 1) ? 0 : m_ch + 1;
        for (int n = 0; n < NS; n++) begin
            logic [15:0] w;
            int s, c, p;
            w = cm[n][m_ch];
            rx[n] = 8'(frame * 37 + n * 16 + m_ch * 3 + 1);
            s = int'(w[10:7]);
            c = int'(w[6:0]) & (nch - 1);
            if (w[13]) begin
                exp_b[n] = w[7:0]; exp_k[n] = 1'b1;
            end else begin
                p = (!w[14] && c < m_ch) ? m_par : 1 - m_par;
                exp_b[n] = store[p][s][c]; exp_k[n] = known[p][s][c];
            end
        end
        @(negedge clk);
        slot_stb = 1'b1; frame_sync = sync;
        for (int n = 0; n < NS; n++) rx_bytes[n*8 +: 8] = rx[n];
        @(negedge clk);
        slot_stb = 1'b0; frame_sync = 1'b0;
        chk(tx_vld == 1'b0, "R4 valid one cycle early", tx_vld, 0);
        @(negedge clk);
        chk(tx_vld == 1'b1, "R4 valid after two cycles", tx_vld, 1);
        chk(tx_ch == CHW'(m_ch), "R1 channel number", tx_ch, m_ch);
        for (int n = 0; n < NS; n++) begin
            logic [15:0] w;
            w = cm[n][m_ch];
            chk(tx_oe[n] == w[11], "R8 output enable", tx_oe[n], w[11]);
            chk(tx_cco[n] == cm[n][nxt][12], "R10 early control bit", tx_cco[n], cm[n][nxt][12]);
            if (exp_k[n]) begin
                if (w[13])
                    chk(tx_bytes[n*8 +: 8] == exp_b[n], "R7 constant byte", tx_bytes[n*8 +: 8], exp_b[n]);
                else if (w[14])
                    chk(tx_bytes[n*8 +: 8] == exp_b[n], "R5 R3 fixed delay byte", tx_bytes[n*8 +: 8], exp_b[n]);
                else
                    chk(tx_bytes[n*8 +: 8] == exp_b[n], "R6 R3 R2 variable delay byte", tx_bytes[n*8 +: 8], exp_b[n]);
            end
            // R9: loopback stores the transmitted byte instead of rx.
            store[m_par][n][m_ch] = w[15] ? exp_b[n] : rx[n];
            known[m_par][n][m_ch] = w[15] ? exp_k[n] : 1'b1;
        end
        @(negedge clk);
        chk(tx_vld == 1'b0 && tx_oe == '0, "R4 R8 idle after slot", {tx_vld, tx_oe}, 0);
    endtask

    task automatic run_frames(input int nf);
        for (int f = 0; f < nf; f++)
            for (int m = 0; m < nch; m++)
                do_slot(m == 0);
    endtask

    initial begin
        for (int p = 0; p < 2; p++)
            for (int n = 0; n < NS; n++)
                for (int m = 0; m < CH_MAX; m++) known[p][n][m] = 1'b0;

        repeat (4) @(negedge clk);
        chk(tx_vld == 1'b0, "R4 reset valid", tx_vld, 0);
        chk(tx_oe == '0, "R8 reset enable", tx_oe, 0);
        rst_n = 1'b1;

        // Pattern A: mixed delays, junk above the channel mask, some constants.
        for (int n = 0; n < NS; n++)
            for (int m = 0; m < CH_MAX; m++)
                host_write(n, m, mk(1'b0, m[0], (n == 3 && m % 4 == 0), 1'((n ^ m) & 1),
                                    ((n + m) % 3) != 0, (n + 1) % NS,
                                    ((m * 5 + 3) % 16) | 7'h40, 8'h5A + m));
        set_rate(2);
        run_frames(3);

        // R11: readback, then read-before-write in the same cycle.
        for (int k = 0; k < 6; k++) begin
            int n, m;
            n = k % NS; m = (k * 7) % CH_MAX;
            @(negedge clk);
            host_addr = AW'(n * CH_MAX + m);
            @(negedge clk);
            chk(host_rdata == cm[n][m], "R11 readback", host_rdata, cm[n][m]);
        end
        @(negedge clk);
        host_addr = AW'(1 * CH_MAX + 2); host_we = 1'b1; host_wdata = cm[1][2] ^ 16'h0800;
        @(negedge clk);
        host_we = 1'b0;
        chk(host_rdata == cm[1][2], "R11 old word on write cycle", host_rdata, cm[1][2]);
        cm[1][2] = cm[1][2] ^ 16'h0800;
        @(negedge clk);
        chk(host_rdata == cm[1][2], "R11 new word after write", host_rdata, cm[1][2]);

        // R2: other rates, wrap and mask.
        set_rate(0);
        run_frames(2);
        set_rate(1);
        run_frames(2);
        set_rate(3);
        run_frames(2);

        // Pattern B: loopback on stream 2 with constant bytes.
        for (int m = 0; m < CH_MAX; m++) begin
            host_write(2, m, mk(1'b1, 1'b0, 1'b1, m[1], 1'b1, 0, 0, 8'hA0 + m));
            host_write(0, m, mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2, m, 0));
            host_write(1, m, mk(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2, (m + CH_MAX - 1) % CH_MAX, 0));
            host_write(3, m, mk(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 3, m, 0));
        end
        set_rate(2);
        run_frames(3);
        // R9: stream 2 receive bytes are ignored; stored value is the constant.
        chk(known[1 - m_par][2][5] && store[1 - m_par][2][5] == 8'hA5,
            "R9 loopback model state", store[1 - m_par][2][5], 8'hA5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule